// File: doc/BRIEF.md
# Register File with Single-Error Correction and Error Reporting

This block holds the general-purpose registers of a processor core: 32 words of 32 bits, two read ports and one write port. Every word is stored with a seven-bit single-error-correct, double-error-detect code (a Hamming code plus a parity bit over the whole codeword). Each enabled read is decoded against its stored code. A single flipped bit is repaired in the returned data but not in the array. Every detected event is reported to outside monitoring logic through a registered two-bit status and a four-bit source identifier.

An uncorrectable error sets a sticky halt output that tells the pipeline to stall. It stays set until the synchronous active-low reset is applied. While halted, the block drops all writes. Register x0 is hard-wired to zero and takes no part in error checking. For test, a debug inject port XORs a mask into the stored codeword of a chosen entry, so that single-bit and double-bit faults can be created on purpose.

Top module: `ecc_regfile`

## Requirements
- R1: A write with `wr_en` high to a nonzero address stores `wr_data`. A later read on either port returns that word combinationally on the same cycle the address is presented.
- R2: Address 0 always reads as zero. Writes and injections aimed at it have no effect, and a read of it never produces an error report.
- R3: When the stored 39-bit codeword of an entry differs from its written value in exactly one bit (any position 0 to 38 of `inj_mask`), a read returns the original data. On the cycle after that read, status is 2'b10 and source is 4'b0001.
- R4: A corrected word is not written back. Every further read of the same entry reports 2'b10 again until the entry is rewritten.
- R5: When the codeword differs in exactly two bits, a read produces status 2'b11 and source 4'b0001 on the next cycle, and `halt` rises on that same cycle.
- R6: Once set, `halt` stays high until reset. While it is high, writes are ignored, while reads and error reporting continue.
- R7: On any cycle after a cycle with no event on an enabled read, status is 2'b00 and source is 4'b0000. Status 2'b01 and sources 4'b0010 to 4'b1111 are never driven. Status and source are nonzero together.
- R8: When both ports see errors in the same cycle, an uncorrectable result on either port makes the reported status 2'b11. Two correctable results report 2'b10.
- R9: A clock edge with `rst_n` low clears `halt`, status and source. Array contents are kept.
- R10: `inj_en` XORs `inj_mask` into the entry at `inj_addr`. If an accepted write targets the same entry in the same cycle, the injection is dropped and the written word is stored clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of halt and report registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_en_a | input | 1 | Read enable, port A |
| rd_addr_a | input | 5 | Read address, port A |
| rd_data_a | output | 32 | Read data (corrected), port A |
| rd_en_b | input | 1 | Read enable, port B |
| rd_addr_b | input | 5 | Read address, port B |
| rd_data_b | output | 32 | Read data (corrected), port B |
| inj_en | input | 1 | Debug fault injection enable |
| inj_addr | input | 5 | Entry to receive the injected flips |
| inj_mask | input | 39 | Bits of the stored codeword to invert |
| ecc_status | output | 2 | Error status: 00 none, 10 corrected, 11 uncorrectable |
| ecc_source | output | 4 | Error source: 0000 none, 0001 register file |
| halt | output | 1 | Sticky stall request after an uncorrectable error |

## Verification
The bench flips every one of the 39 codeword positions in turn, including the check bits and the overall parity bit. A decoder with a wrong syndrome mapping would then return damaged data or misclassify the event. It reads a corrected entry twice, so a design that quietly wrote the repair back would go silent on the second read. It injects into an entry in the same cycle as a write to it, and into x0, where a missed guard would leave a stale fault or report a phantom event. It pairs a correctable error on one port with an uncorrectable one on the other, where a wrong priority would understate the severity. It also writes while halted and then reads back, so a leaky write gate would show up as changed data.

// File: rtl/ecc_rf_pkg.sv
// Shared definitions for the protected register file.
// Assumes a Hamming code with positions numbered from 1 and an extra
// overall parity bit kept in codeword bit 0.
package ecc_rf_pkg;

    typedef enum logic [1:0] {
        ST_NONE   = 2'b00,
        ST_CORR   = 2'b10,
        ST_UNCORR = 2'b11
    } ecc_stat_e;

    localparam logic [3:0] SRC_NONE = 4'b0000;
    localparam logic [3:0] SRC_GPR  = 4'b0001;

    // Number of Hamming check bits needed to cover dw data bits
    function automatic int ham_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

endpackage

// File: rtl/ecc_rf_encode.sv
// Builds the stored codeword from a data word.
// Layout: cw[pos] for pos 1..N is the Hamming position, with check bits at
// powers of two and data bits filling the rest in ascending order;
// cw[0] is parity over cw[N:1]. Purely combinational.
module ecc_rf_encode #(
    parameter int DATA_W = 32,
    parameter int HAM_P  = 6
) (
    input  logic [DATA_W-1:0]     data,
    output logic [DATA_W+HAM_P:0] cw
);
    localparam int N = DATA_W + HAM_P;

    // Place data, then fill each check position from its coverage group
    always_comb begin
        logic [N:0] w;
        logic       par;
        int         j;
        w   = '0;
        j   = 0;
        par = 1'b0;
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                w[pos] = data[j];
                j++;
            end
        end
        for (int i = 0; i < HAM_P; i++) begin
            par = 1'b0;
            for (int pos = 1; pos <= N; pos++) begin
                if (pos[i]) par = par ^ w[pos];
            end
            w[1 << i] = par;
        end
        w[0] = ^w[N:1];
        cw   = w;
    end
endmodule

// File: rtl/ecc_rf_decode.sv
// Checks a stored codeword and returns repaired data.
// Assumes the layout produced by ecc_rf_encode. A set overall parity with a
// syndrome inside the codeword is a single error and is repaired; a clear
// overall parity with a nonzero syndrome, or an out-of-range syndrome, is
// reported as uncorrectable and the data bits are passed through as stored.
module ecc_rf_decode #(
    parameter int DATA_W = 32,
    parameter int HAM_P  = 6
) (
    input  logic [DATA_W+HAM_P:0] cw,
    output logic [DATA_W-1:0]     data,
    output logic                  corr,
    output logic                  uncorr
);
    localparam int N = DATA_W + HAM_P;

    logic [HAM_P-1:0] syn;
    logic             ovp;
    logic [N:0]       fixed;

    // Syndrome and overall parity over the received word
    always_comb begin
        syn = '0;
        for (int i = 0; i < HAM_P; i++) begin
            for (int pos = 1; pos <= N; pos++) begin
                if (pos[i]) syn[i] = syn[i] ^ cw[pos];
            end
        end
        ovp = ^cw;
    end

    // Classify the event and flip the located bit
    always_comb begin
        fixed  = cw;
        corr   = ovp && (int'(syn) <= N);
        uncorr = (!ovp && (syn != '0)) || (ovp && (int'(syn) > N));
        if (corr) begin
            for (int pos = 1; pos <= N; pos++) begin
                if (int'(syn) == pos) fixed[pos] = ~cw[pos];
            end
        end
    end

    // Gather data bits back out of the non-check positions
    always_comb begin
        int j;
        j    = 0;
        data = '0;
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data[j] = fixed[pos];
                j++;
            end
        end
    end
endmodule

// File: rtl/ecc_rf_report.sv
// Merges per-port events into the registered status/source pair and keeps
// the sticky halt latch. Assumes synchronous active-low reset.
module ecc_rf_report
    import ecc_rf_pkg::*;
#(
    parameter int NUM_RD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ecc_stat_e         evt [NUM_RD],
    output logic [1:0]        ecc_status,
    output logic [3:0]        ecc_source,
    output logic              halt
);
    ecc_stat_e worst;

    // Uncorrectable outranks correctable across all ports
    always_comb begin
        worst = ST_NONE;
        for (int p = 0; p < NUM_RD; p++) begin
            if (evt[p] == ST_UNCORR) worst = ST_UNCORR;
            else if (evt[p] == ST_CORR && worst == ST_NONE) worst = ST_CORR;
        end
    end

    // Register the report for one cycle and latch halt on fatal errors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_status <= ST_NONE;
            ecc_source <= SRC_NONE;
            halt       <= 1'b0;
        end else begin
            ecc_status <= worst;
            ecc_source <= (worst == ST_NONE) ? SRC_NONE : SRC_GPR;
            if (worst == ST_UNCORR) halt <= 1'b1;
        end
    end
endmodule

// File: rtl/ecc_regfile.sv
// Register file with per-word SECDED protection, error reporting and a
// debug fault-injection port. Reads are combinational; the report is
// registered. The array is not reset; x0 is never stored or checked.
module ecc_regfile
    import ecc_rf_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int HAM_P  = ham_bits(DATA_W),
    localparam int CW_W   = DATA_W + HAM_P + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_a,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic              rd_en_b,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [CW_W-1:0]   inj_mask,
    output logic [1:0]        ecc_status,
    output logic [3:0]        ecc_source,
    output logic              halt
);
    localparam int NUM_RD = 2;

    logic [CW_W-1:0]   mem [DEPTH];
    logic [CW_W-1:0]   wr_cw;
    logic              wr_ok;
    logic              inj_ok;
    logic              rd_en   [NUM_RD];
    logic [ADDR_W-1:0] rd_addr [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];
    ecc_stat_e         evt     [NUM_RD];

    ecc_rf_encode #(.DATA_W(DATA_W), .HAM_P(HAM_P)) u_enc (
        .data (wr_data),
        .cw   (wr_cw)
    );

    // Write gating: no writes to x0 or while halted; write beats injection
    always_comb begin
        wr_ok  = wr_en && !halt && (wr_addr != '0);
        inj_ok = inj_en && (inj_addr != '0) && !(wr_ok && (wr_addr == inj_addr));
    end

    // Array update from the write port and the debug injector
    always_ff @(posedge clk) begin
        if (wr_ok)  mem[wr_addr]  <= wr_cw;
        if (inj_ok) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    end

    // Bundle the two read ports for the generate loop
    always_comb begin
        rd_en[0]   = rd_en_a;
        rd_addr[0] = rd_addr_a;
        rd_en[1]   = rd_en_b;
        rd_addr[1] = rd_addr_b;
        rd_data_a  = rd_data[0];
        rd_data_b  = rd_data[1];
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic [DATA_W-1:0] dec_data;
        logic              dec_corr;
        logic              dec_uncorr;
        logic              live;

        ecc_rf_decode #(.DATA_W(DATA_W), .HAM_P(HAM_P)) u_dec (
            .cw     (mem[rd_addr[p]]),
            .data   (dec_data),
            .corr   (dec_corr),
            .uncorr (dec_uncorr)
        );

        // Zero for x0, classify only enabled reads of real entries
        always_comb begin
            live       = rd_en[p] && (rd_addr[p] != '0);
            rd_data[p] = (rd_addr[p] == '0) ? '0 : dec_data;
            if (!live)           evt[p] = ST_NONE;
            else if (dec_uncorr) evt[p] = ST_UNCORR;
            else if (dec_corr)   evt[p] = ST_CORR;
            else                 evt[p] = ST_NONE;
        end
    end

    ecc_rf_report #(.NUM_RD(NUM_RD)) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .ecc_status (ecc_status),
        .ecc_source (ecc_source),
        .halt       (halt)
    );
endmodule

// File: rtl/ecc_regfile_chk.sv
// Protocol checks on the register file ports, attached by bind.
// Assumes synchronous active-low reset; all properties are off in reset.
module ecc_regfile_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_a,
    input logic              rd_en_b,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [1:0]        ecc_status,
    input logic [3:0]        ecc_source,
    input logic              halt
);
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_status != 2'b01); // R7
    AST_SOURCE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_source == 4'b0000 || ecc_source == 4'b0001); // R7
    AST_SOURCE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_status == 2'b00) == (ecc_source == 4'b0000)); // R7
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_a && !rd_en_b) |=> ecc_status == 2'b00); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt); // R6
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> ecc_status == 2'b11); // R5
    AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> rd_data_a == '0); // R2
endmodule

bind ecc_regfile ecc_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_a    (rd_en_a),
    .rd_en_b    (rd_en_b),
    .rd_addr_a  (rd_addr_a),
    .rd_data_a  (rd_data_a),
    .ecc_status (ecc_status),
    .ecc_source (ecc_source),
    .halt       (halt)
);

// File: tb/ecc_regfile_bench.sv
// Self-checking bench: a behavioural model keeps each entry's data and the
// number of bits flipped in it since the last write; status is predicted
// from that count and compared every clock.
module ecc_regfile_bench;
    localparam int CW_W = 39;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en_a = 1'b0, rd_en_b = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic        inj_en = 1'b0;
    logic [4:0]  inj_addr = '0;
    logic [CW_W-1:0] inj_mask = '0;
    logic [1:0]  ecc_status;
    logic [3:0]  ecc_source;
    logic        halt;

    int n_chk = 0, n_fail = 0;

    logic [31:0] m_data  [32];
    int          m_flips [32];
    logic        m_halt = 1'b0;
    logic [1:0]  m_stat = 2'b00;

    always #2.5 clk = ~clk;

    ecc_regfile u_ecc_regfile (.*);

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] cls(logic en, logic [4:0] a);
        if (!en || a == 0) return 2'b00;
        if (m_flips[a] >= 2) return 2'b11;
        if (m_flips[a] == 1) return 2'b10;
        return 2'b00;
    endfunction

    // One clock: check reads, predict, advance model, check report
    task automatic tick(string req);
        logic [1:0] ea, eb;
        logic       wacc;
        #1;
        if (rd_en_a && m_flips[rd_addr_a] < 2)
            check(req, "rd_data_a", rd_data_a, rd_addr_a == 0 ? 32'h0 : m_data[rd_addr_a]);
        if (rd_en_b && m_flips[rd_addr_b] < 2)
            check(req, "rd_data_b", rd_data_b, rd_addr_b == 0 ? 32'h0 : m_data[rd_addr_b]);
        ea = cls(rd_en_a, rd_addr_a);
        eb = cls(rd_en_b, rd_addr_b);
        m_stat = (ea == 2'b11 || eb == 2'b11) ? 2'b11 :
                 (ea == 2'b10 || eb == 2'b10) ? 2'b10 : 2'b00;
        wacc = wr_en && !m_halt && wr_addr != 0;
        if (wacc) begin
            m_data[wr_addr]  = wr_data;
            m_flips[wr_addr] = 0;
        end
        if (inj_en && inj_addr != 0 && !(wacc && inj_addr == wr_addr))
            m_flips[inj_addr] += $countones(inj_mask);
        if (m_stat == 2'b11) m_halt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(req, "ecc_status", ecc_status, m_stat);
        check(req, "ecc_source", ecc_source, m_stat == 2'b00 ? 4'h0 : 4'h1);
        check(req, "halt", halt, m_halt);
        wr_en = 0; rd_en_a = 0; rd_en_b = 0; inj_en = 0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d, string req);
        wr_en = 1; wr_addr = a; wr_data = d; tick(req);
    endtask

    task automatic rd2(logic [4:0] a, logic [4:0] b, string req);
        rd_en_a = 1; rd_addr_a = a; rd_en_b = 1; rd_addr_b = b; tick(req);
    endtask

    task automatic inj(logic [4:0] a, logic [CW_W-1:0] m, string req);
        inj_en = 1; inj_addr = a; inj_mask = m; tick(req);
    endtask

    task automatic do_reset(string req);
        rst_n = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1;
        m_halt = 0; m_stat = 2'b00;
        check(req, "halt after reset", halt, 1'b0);
        check(req, "status after reset", ecc_status, 2'b00);
        check(req, "source after reset", ecc_source, 4'h0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_data[i] = '0; m_flips[i] = 0; end
        @(negedge clk);
        do_reset("R9");

        // R1: fill and read back on both ports
        for (int i = 1; i < 32; i++) wr(5'(i), 32'h9E37_79B9 * i ^ 32'h0F0F_A5A5, "R1");
        wr(5'd0, 32'hDEAD_BEEF, "R2");
        for (int i = 0; i < 32; i++) rd2(5'(i), 5'(31 - i), "R1");

        // R7: idle cycles stay quiet
        tick("R7");

        // R3/R4: every single-bit position, read twice, then scrub by rewrite
        for (int k = 0; k < CW_W; k++) begin
            logic [4:0] e;
            e = 5'(1 + (k % 31));
            inj(e, CW_W'(1) << k, "R3");
            rd2(e, 5'd0, "R3");
            rd2(5'd0, e, "R4");
            wr(e, m_data[e] ^ 32'h1357_9BDF, "R4");
        end

        // R2: injection into x0 is ignored
        inj(5'd0, CW_W'(3), "R2");
        rd2(5'd0, 5'd0, "R2");

        // R10: inject colliding with a write to the same entry is dropped
        wr_en = 1; wr_addr = 5'd7; wr_data = 32'hCAFE_0007;
        inj_en = 1; inj_addr = 5'd7; inj_mask = CW_W'(3);
        tick("R10");
        rd2(5'd7, 5'd7, "R10");

        // R8: two correctable errors together stay correctable
        inj(5'd3, CW_W'(1) << 9, "R8");
        inj(5'd4, CW_W'(1) << 20, "R8");
        rd2(5'd3, 5'd4, "R8");

        // R8/R5: correctable on A, uncorrectable on B
        inj(5'd9, (CW_W'(1) << 2) | (CW_W'(1) << 30), "R8");
        rd2(5'd3, 5'd9, "R8");

        // R6: sticky halt, writes dropped, reads still served
        for (int i = 0; i < 4; i++) tick("R6");
        wr(5'd12, 32'h1111_2222, "R6");
        rd2(5'd12, 5'd3, "R6");
        check("R6", "halt still set", halt, 1'b1);

        // R9: reset clears halt; array retained
        do_reset("R9");
        rd2(5'd12, 5'd1, "R9");

        // R5: double error alone on port A
        wr(5'd9, 32'h0BAD_F00D, "R5");
        inj(5'd20, (CW_W'(1) << 0) | (CW_W'(1) << 38), "R5");
        rd_en_a = 1; rd_addr_a = 5'd20; tick("R5");
        tick("R5");
        do_reset("R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule